// File: doc/BRIEF.md
# Tree Reduction Operand Scheduler

This block walks a fixed, deterministic tree-reduction schedule over a vector of N elements and emits one element index per scheduled operation. Each operation combines two elements in place. The left index is also the destination, and the right index is the element folded into it. N does not have to be a power of two. Pairs whose right element would fall past the end of the vector are left out, so the schedule holds exactly N-1 operations. No element moves are ever scheduled.

One stream carries one operand side. A side-select input, captured at start, chooses whether the stream carries the left indices or the right indices. Two instances started with the same length and order flags, but with opposite side selects, therefore produce the two operand streams of one reduction in lockstep. A reverse flag mirrors every index, so the reduced value gathers in the last element instead of the first. A halving flag runs the passes from the widest step down to step 2, instead of from step 2 upward. Indices leave through a valid/ready handshake, and a one-cycle done pulse marks the end of each schedule.

Top module: `tred_sched`

## Requirements
- R1: After reset, outValid and done are both low, and the block is idle until start is seen.
- R2: In the default order (revOrder=0, halveStep=0), passes use steps s = 2, 4, 8 and so on. Within a pass, i takes the values 0, s, 2s and so on, and the pair (left=i, right=i+s/2) is emitted only when i+s/2 < N. Pairs are emitted in order of increasing i. The pass whose step s is at least N is the last one.
- R3: With pickRight=0 the stream carries the left index of each pair. With pickRight=1 it carries the right index of the same pair, in the same order.
- R4: With revOrder=1, every index x of the R2/R6 schedule is replaced by N-1-x. Every left index is then greater than its right index, and after a default-step reduction the total sits in element N-1.
- R5: With revOrder=0, every left index is less than its right index, and after a default-step reduction the total sits in element 0.
- R6: With halveStep=1, the passes use steps S, S/2, ..., 2, where S is the smallest power of two that is at least N. The pairing within each pass is the same as in R2.
- R7: A start with len of 0 or 1 produces no valid output, and done is high in the cycle after start is sampled.
- R8: Each schedule holds exactly N-1 operations. A len above 2^IDX_W (128 by default) is treated as 2^IDX_W, which limits a schedule to 127 operations.
- R9: While outValid is high and outReady is low, outValid stays high and outIndex does not change. The schedule advances only on a cycle where both outValid and outReady are high.
- R10: done is high for exactly one cycle, in the cycle after the final transfer, and outValid is low in that cycle. The block then returns to idle. A start received while a schedule is running or finishing is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a schedule when the block is idle |
| len | input | IDX_W+1 | Element count N, captured at start |
| revOrder | input | 1 | 1 = mirrored indices, result in the last element |
| halveStep | input | 1 | 1 = steps run from widest down to 2 |
| pickRight | input | 1 | 0 = stream left indices, 1 = stream right indices |
| outValid | output | 1 | An index is offered |
| outReady | input | 1 | The consumer takes the offered index |
| outIndex | output | IDX_W | Offered element index |
| done | output | 1 | One-cycle pulse at the end of a schedule |

## Verification
The bench targets lengths that are not powers of two, such as 6, 11 and 13. At these lengths the last pair of a pass would run past the end. A design that got the cut-off wrong would emit an index equal to or above N, or would drop a legal pair from the stream.

The bench also uses lengths of 0 and 1, which have no operations, and a length of 200, which must be clamped. A design with a wrong boundary would hang, emit a pair, or run past 127 operations.

For both orders, the bench combines the streams of the two sides from separate runs and replays them over known values. It then checks that the whole sum lands in element 0, or in element N-1 when the order is reversed. A wrong mirror or a wrong step order would leave part of the vector unreduced.

The bench stalls the consumer to catch an index that changes or vanishes while it waits. It also sends a stray start in the middle of a run, which must not splice a second schedule onto the first.

// File: rtl/tred_pkg.sv
package tred_pkg;

  // Strobes sent from the control FSM to the datapath.
  typedef struct packed {
    logic load;     // capture length and flags, reset the walk
    logic advance;  // current pair taken by the consumer
  } tred_strobe_t;

  // Walk position reported from the datapath back to the control.
  typedef struct packed {
    logic lastInPass;  // the current pair is the last one of its pass
    logic lastPass;    // the current pass is the final one
  } tred_status_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tred_state_t;

endpackage

// File: rtl/tred_ctrl.sv
module tred_ctrl
  import tred_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         shortLen,
  input  logic         outReady,
  input  tred_status_t status,
  output tred_strobe_t strobe,
  output logic         outValid,
  output logic         done,
  output logic         idle
);

  tred_state_t stateQ, stateD;

  always_comb begin
    idle           = (stateQ == ST_IDLE);
    outValid       = (stateQ == ST_RUN);
    done           = (stateQ == ST_DONE);
    strobe.load    = idle && start;
    strobe.advance = outValid && outReady;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stateD = shortLen ? ST_DONE : ST_RUN;
        end
      end
      ST_RUN: begin
        if (outReady && status.lastInPass && status.lastPass) begin
          stateD = ST_DONE;
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

endmodule

// File: rtl/tred_datapath.sv
module tred_datapath
  import tred_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  tred_strobe_t     strobe,
  input  logic [IDX_W:0]   lenIn,
  input  logic             revIn,
  input  logic             halveIn,
  input  logic             pickRightIn,
  output logic             shortLen,
  output tred_status_t     status,
  output logic [IDX_W-1:0] outIndex
);

  localparam int LEN_W = IDX_W + 1;
  localparam int AW    = IDX_W + 2;
  localparam logic [LEN_W-1:0] MAX_N = LEN_W'(1) << IDX_W;

  // Smallest power of two p such that 2*p >= n (first half-step when halving).
  function automatic logic [IDX_W-1:0] firstHalf(input logic [LEN_W-1:0] n);
    logic [IDX_W-1:0] p;
    p = IDX_W'(1) << (IDX_W - 1);
    for (int k = IDX_W - 1; k >= 0; k--) begin
      if ((32'd2 << k) >= 32'(n)) begin
        p = IDX_W'(32'd1 << k);
      end
    end
    return p;
  endfunction

  logic [LEN_W-1:0] effLen;
  logic [LEN_W-1:0] lenQ;
  logic [IDX_W-1:0] lastQ;
  logic [IDX_W-1:0] baseQ;
  logic [IDX_W-1:0] halfQ;
  logic             revQ, halveQ, pickQ;

  logic [AW-1:0]    nextPairRight;
  logic [IDX_W-1:0] leftRaw, rightRaw, sideRaw;

  always_comb begin
    effLen   = (lenIn > MAX_N) ? MAX_N : lenIn;
    shortLen = (effLen < LEN_W'(2));
  end

  // Right index of the pair that would follow in this pass: base + step + half.
  always_comb begin
    nextPairRight = {2'b00, baseQ} + {1'b0, halfQ, 1'b0} + {2'b00, halfQ};
    status.lastInPass = (nextPairRight >= {1'b0, lenQ});
    if (halveQ) begin
      status.lastPass = (halfQ == IDX_W'(1));
    end else begin
      status.lastPass = ({halfQ, 1'b0} >= lenQ);
    end
  end

  always_comb begin
    leftRaw  = baseQ;
    rightRaw = baseQ + halfQ;
    sideRaw  = pickQ ? rightRaw : leftRaw;
    outIndex = revQ ? (lastQ - sideRaw) : sideRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ   <= '0;
      lastQ  <= '0;
      baseQ  <= '0;
      halfQ  <= IDX_W'(1);
      revQ   <= 1'b0;
      halveQ <= 1'b0;
      pickQ  <= 1'b0;
    end else if (strobe.load) begin
      lenQ   <= effLen;
      lastQ  <= IDX_W'(effLen - LEN_W'(1));
      baseQ  <= '0;
      halfQ  <= halveIn ? firstHalf(effLen) : IDX_W'(1);
      revQ   <= revIn;
      halveQ <= halveIn;
      pickQ  <= pickRightIn;
    end else if (strobe.advance) begin
      if (status.lastInPass) begin
        baseQ <= '0;
        halfQ <= halveQ ? (halfQ >> 1) : (halfQ << 1);
      end else begin
        baseQ <= IDX_W'(baseQ + {halfQ, 1'b0});
      end
    end
  end

endmodule

// File: rtl/tred_sched.sv
module tred_sched
  import tred_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W:0]   len,
  input  logic             revOrder,
  input  logic             halveStep,
  input  logic             pickRight,
  output logic             outValid,
  input  logic             outReady,
  output logic [IDX_W-1:0] outIndex,
  output logic             done
);

  tred_strobe_t strobe;
  tred_status_t status;
  logic         shortLen;
  logic         idle;

  tred_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .shortLen (shortLen),
    .outReady (outReady),
    .status   (status),
    .strobe   (strobe),
    .outValid (outValid),
    .done     (done),
    .idle     (idle)
  );

  tred_datapath #(.IDX_W(IDX_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .lenIn       (len),
    .revIn       (revOrder),
    .halveIn     (halveStep),
    .pickRightIn (pickRight),
    .shortLen    (shortLen),
    .status      (status),
    .outIndex    (outIndex)
  );

endmodule

// File: rtl/tred_sched_chk.sv
module tred_sched_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [IDX_W:0]   len,
  input logic             outValid,
  input logic             outReady,
  input logic [IDX_W-1:0] outIndex,
  input logic             done,
  input logic             idle
);

  localparam int CW = IDX_W + 1;
  localparam logic [CW-1:0] CAP = CW'(1) << IDX_W;

  logic [CW-1:0] opCount;
  logic [CW-1:0] expOps;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opCount <= '0;
      expOps  <= '0;
    end else if (start && idle) begin
      opCount <= '0;
      if (len < CW'(2)) begin
        expOps <= '0;
      end else if (len > CAP) begin
        expOps <= CAP - CW'(1);
      end else begin
        expOps <= len - CW'(1);
      end
    end else if (outValid && outReady) begin
      opCount <= opCount + CW'(1);
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid); // R9

  AST_HOLD_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outIndex)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && idle); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid); // R10

  AST_OP_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> opCount == expOps); // R8

  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    start && idle && (len < CW'(2)) |=> done && !outValid); // R7

endmodule

bind tred_sched tred_sched_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .len      (len),
  .outValid (outValid),
  .outReady (outReady),
  .outIndex (outIndex),
  .done     (done),
  .idle     (idle)
);

// File: tb/sim_tred_sched.sv
`timescale 1ns/1ps
module sim_tred_sched;

  localparam int IDX_W = 7;
  localparam int MAXN  = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [IDX_W:0]   len = '0;
  logic             revOrder = 1'b0;
  logic             halveStep = 1'b0;
  logic             pickRight = 1'b0;
  logic             outValid;
  logic             outReady = 1'b1;
  logic [IDX_W-1:0] outIndex;
  logic             done;

  always #2 clk = ~clk;  // 250 MHz

  tred_sched #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .len(len),
    .revOrder(revOrder), .halveStep(halveStep), .pickRight(pickRight),
    .outValid(outValid), .outReady(outReady), .outIndex(outIndex), .done(done)
  );

  int    checks = 0;
  int    failures = 0;
  int    expQ[$];
  int    obsQ[$];
  int    doneCnt = 0;
  bit    stallMode = 1'b0;
  string curTag = "R1";
  bit    prevStall = 1'b0;
  int    prevIdx = 0;
  int    leftArr[$];
  int    rightArr[$];
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: sampled at the falling edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall) begin
        chk(outValid === 1'b1, "R9 valid held while stalled", int'(outValid), 1);
        chk(int'(outIndex) == prevIdx, "R9 index stable while stalled", int'(outIndex), prevIdx);
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, {curTag, " unexpected item (R10)"}, int'(outIndex), -1);
        end else begin
          int e;
          e = expQ.pop_front();
          chk(int'(outIndex) == e, curTag, int'(outIndex), e);
        end
        obsQ.push_back(int'(outIndex));
      end
      if (done) doneCnt++;
      prevStall = outValid && !outReady;
      prevIdx   = int'(outIndex);
    end
  end

  // Ready driver, applied just after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      outReady = stallMode ? lfsr[0] : 1'b1;
    end
  end

  // Expected schedule straight from R2, R3, R4, R6, R8.
  task automatic buildExp(input int n, input bit rev, input bit halve, input bit pick);
    int effN;
    int s;
    int v;
    effN = (n > MAXN) ? MAXN : n;
    expQ.delete();
    if (effN < 2) return;
    s = 2;
    if (halve) while (s < effN) s = s * 2;
    forever begin
      for (int i = 0; i + s / 2 < effN; i += s) begin
        v = pick ? (i + s / 2) : i;
        if (rev) v = effN - 1 - v;
        expQ.push_back(v);
      end
      if (halve) begin
        if (s == 2) break;
        s = s / 2;
      end else begin
        if (s >= effN) break;
        s = s * 2;
      end
    end
  endtask

  task automatic runCase(input string tag, input int n, input bit rev, input bit halve,
                         input bit pick, input bit stall, input bit stray);
    int expCount;
    buildExp(n, rev, halve, pick);
    expCount = expQ.size();
    obsQ.delete();
    curTag = tag;
    stallMode = stall;
    @(posedge clk); #1;
    doneCnt = 0;
    len = (IDX_W+1)'(n);
    revOrder = rev; halveStep = halve; pickRight = pick;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (stray) begin
      repeat (3) @(posedge clk);
      #1;
      len = (IDX_W+1)'(5); revOrder = ~rev; pickRight = ~pick;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (doneCnt == 0) @(negedge clk);
    chk(expQ.size() == 0, {tag, " all pairs emitted"}, expQ.size(), 0);
    chk(obsQ.size() == expCount, {tag, " op count (R8)"}, obsQ.size(), expCount);
    @(negedge clk);
    chk(doneCnt == 1, "R10 done one cycle", doneCnt, 1);
    chk(outValid == 1'b0, "R10 idle after done", int'(outValid), 0);
    stallMode = 1'b0;
  endtask

  // Replays the two operand streams over values k+1 and checks where the total lands.
  task automatic landCheck(input string tag, input int n, input bit rev);
    int acc[$];
    int total;
    int target;
    acc.delete();
    total = 0;
    for (int k = 0; k < n; k++) begin
      acc.push_back(k + 1);
      total += k + 1;
    end
    chk(leftArr.size() == rightArr.size(), {tag, " stream lengths"}, leftArr.size(), rightArr.size());
    for (int p = 0; p < leftArr.size() && p < rightArr.size(); p++) begin
      if (rev) chk(leftArr[p] > rightArr[p], {tag, " left above right"}, leftArr[p], rightArr[p]);
      else     chk(leftArr[p] < rightArr[p], {tag, " left below right"}, leftArr[p], rightArr[p]);
      acc[leftArr[p]] = acc[leftArr[p]] + acc[rightArr[p]];
    end
    target = rev ? n - 1 : 0;
    chk(acc[target] == total, {tag, " total lands in end element"}, acc[target], total);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 reset outValid", int'(outValid), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);

    runCase("R2 N=8 left", 8, 0, 0, 0, 0, 0);
    runCase("R3 N=8 right", 8, 0, 0, 1, 0, 0);
    runCase("R2 N=6 left stalled (R9)", 6, 0, 0, 0, 1, 0);
    runCase("R4 N=6 right reversed", 6, 1, 0, 1, 1, 0);
    runCase("R6 N=11 halving left", 11, 0, 1, 0, 0, 0);
    runCase("R6 N=11 halving right stalled", 11, 0, 1, 1, 1, 0);
    runCase("R6 N=16 halving reversed", 16, 1, 1, 0, 0, 0);
    runCase("R8 N=200 clamped", 200, 0, 0, 1, 0, 0);
    runCase("R8 N=128 reversed", 128, 1, 0, 0, 1, 0);
    runCase("R10 stray start", 9, 0, 0, 0, 0, 1);

    // R7: empty schedules
    for (int n = 0; n < 2; n++) begin
      @(posedge clk); #1;
      doneCnt = 0;
      curTag = "R7 empty schedule";
      len = (IDX_W+1)'(n);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      @(negedge clk);
      chk(done == 1'b1, "R7 done right after start", int'(done), 1);
      chk(outValid == 1'b0, "R7 no valid output", int'(outValid), 0);
      @(negedge clk);
      chk(done == 1'b0 && outValid == 1'b0, "R7 back to idle", int'(done), 0);
    end

    // R5 / R4: result landing with the two streams
    runCase("R5 N=13 left", 13, 0, 0, 0, 0, 0);
    leftArr = obsQ;
    runCase("R5 N=13 right", 13, 0, 0, 1, 1, 0);
    rightArr = obsQ;
    landCheck("R5", 13, 0);
    runCase("R4 N=13 left rev", 13, 1, 0, 0, 1, 0);
    leftArr = obsQ;
    runCase("R4 N=13 right rev", 13, 1, 0, 1, 0, 0);
    rightArr = obsQ;
    landCheck("R4", 13, 1);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired in %s actual=hung expected=done", curTag);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule